// File: doc/BRIEF.md
# Triggered One-Pulse Generator

This block produces a single shaped pulse each time an external trigger shows a qualifying edge. A prescaler divides the clock, and an up-counter steps from zero to a programmable reload limit at the divided rate. A small state machine walks the output through three states. `ST_WAIT` holds the programmable idle level. `ST_DELAY` still shows the idle level while the count is below the compare value. `ST_PULSE` shows the opposite level from the compare value through the reload limit. When the counter steps past the reload limit, the update event fires, the run stops on its own, the counter clears, and the block waits for the next trigger.

The state transitions are as follows:
- *start*: `ST_WAIT` goes to `ST_DELAY`, or straight to `ST_PULSE` when the compare value is zero.
- *compare*: `ST_DELAY` goes to `ST_PULSE`.
- *update*: `ST_DELAY` or `ST_PULSE` goes to `ST_WAIT` at the reload limit.
- *abort*: any running state goes to `ST_WAIT` when enable is cleared.

The trigger passes through a two-stage synchronizer before edge qualification. A trigger level change that the first clock edge captures therefore moves the machine out of `ST_WAIT` on the third edge. Configuration inputs are used live.

Top module: `trig_pulse_gen`

## Requirements
- R1: While reset is held and right after it, `pulse_out` equals `idle_lvl`, `done` is low and the block is waiting.
- R2: With `edge_sel` = 0, only a rising trigger edge starts a run. A falling edge leaves the output idle.
- R3: With `edge_sel` = 1, only a falling trigger edge starts a run. A rising edge leaves the output idle.
- R4: With `edge_sel` = 2 or 3, either trigger edge starts a run.
- R5: While `enable` is low, trigger edges have no effect: the output stays idle and `done` stays low.
- R6: A trigger change that is first captured at clock edge e0 starts the run at edge e2. The delay phase then lasts `cmp_val`×(`presc_val`+1) clocks at the idle level.
- R7: The active phase shows the inverse of `idle_lvl` for (`reload_val`+1−`cmp_val`)×(`presc_val`+1) clocks and is contiguous.
- R8: With `cmp_val` = 0 the active phase begins at run start. With `cmp_val` > `reload_val` there is no active phase, but the run still ends with an update event.
- R9: The update event falls (`reload_val`+1)×(`presc_val`+1) clocks after run start. `done` is high for exactly that one cycle, the output returns to idle, and the counter restarts from zero for the next trigger, so a later run has identical timing.
- R10: Trigger edges that arrive during a run are ignored: the run is neither restarted nor extended, and only one `done` pulse results.
- R11: `idle_lvl` = 0 gives a low idle level with a high pulse, and `idle_lvl` = 1 gives a high idle level with a low pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | One-pulse operation enable |
| trig | input | 1 | External trigger, asynchronous |
| edge_sel | input | 2 | 0 rising, 1 falling, 2/3 both edges |
| idle_lvl | input | 1 | Output level outside the active phase |
| cmp_val | input | 16 | Compare value: count where the active phase begins |
| reload_val | input | 16 | Reload limit: last count value of a run |
| presc_val | input | 16 | Prescaler: the counter steps every presc_val+1 clocks |
| pulse_out | output | 1 | Shaped pulse output (registered) |
| done | output | 1 | One-cycle update event flag |

## Verification
On every cycle, the checker confirms the following. The output sits at the idle level whenever the machine waits. The active state always shows the inverse level. A run always begins from a zero count, and during a run the count never jumps back, so a retrigger never restarts it. `done` lasts one cycle and only follows a count at the reload limit. The exact lengths of the delay and active phases, the latency from the trigger, and the edge qualification for each `edge_sel` code can be shown only by the bench's timed scenarios. The same holds for the absence of any effect while `enable` is low.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_DELAY = 2'd1,
        ST_PULSE = 2'd2
    } tpg_state_t;

    localparam logic [1:0] EDGE_RISE = 2'd0;
    localparam logic [1:0] EDGE_FALL = 2'd1;

endpackage

// File: rtl/tpg_edge_qual.sv
module tpg_edge_qual #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trig_i,
    input  logic [1:0] sel_i,
    output logic       hit_o
);
    import tpg_pkg::*;

    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] sync_q;
    logic          prev_q;
    logic          rise;
    logic          fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q[0] <= 1'b0;
        end else begin
            sync_q[0] <= trig_i;
        end
    end

    generate
        for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sync_q[i] <= 1'b0;
                end else begin
                    sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= sync_q[LAST];
        end
    end

    assign rise = sync_q[LAST] & ~prev_q;
    assign fall = ~sync_q[LAST] & prev_q;

    always_comb begin
        unique case (sel_i)
            EDGE_RISE: hit_o = rise;
            EDGE_FALL: hit_o = fall;
            default:   hit_o = rise | fall;
        endcase
    end

endmodule

// File: rtl/tpg_prescale.sv
module tpg_prescale #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [PSC_W-1:0] div_i,
    output logic             tick_o
);
    logic [PSC_W-1:0] pc_q;
    logic             wrap;

    assign wrap   = (pc_q >= div_i);
    assign tick_o = run_i & wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (!run_i || wrap) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_q + PSC_W'(1);
        end
    end

endmodule

// File: rtl/tpg_count.sv
module tpg_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] top_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             at_top_o
);
    assign at_top_o = (cnt_o == top_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (!run_i) begin
            cnt_o <= '0;
        end else if (tick_i) begin
            cnt_o <= at_top_o ? '0 : cnt_o + CNT_W'(1);
        end
    end

endmodule

// File: rtl/trig_pulse_gen.sv
module trig_pulse_gen #(
    parameter int CNT_W       = 16,
    parameter int PSC_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             trig,
    input  logic [1:0]       edge_sel,
    input  logic             idle_lvl,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic [CNT_W-1:0] reload_val,
    input  logic [PSC_W-1:0] presc_val,
    output logic             pulse_out,
    output logic             done
);
    import tpg_pkg::*;

    localparam int EXT_W = CNT_W + 1;

    tpg_state_t       state_q;
    tpg_state_t       state_nx;
    logic             hit;
    logic             run;
    logic             tick;
    logic             at_top;
    logic             upd;
    logic             reach_cmp;
    logic [CNT_W-1:0] cnt;

    assign run       = (state_q != ST_WAIT);
    assign reach_cmp = ({1'b0, cnt} + EXT_W'(1)) >= {1'b0, cmp_val};

    tpg_edge_qual #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_i (trig),
        .sel_i  (edge_sel),
        .hit_o  (hit)
    );

    tpg_prescale #(.PSC_W(PSC_W)) u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .div_i  (presc_val),
        .tick_o (tick)
    );

    tpg_count #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run),
        .tick_i   (tick),
        .top_i    (reload_val),
        .cnt_o    (cnt),
        .at_top_o (at_top)
    );

    // next state and update event
    always_comb begin
        state_nx = state_q;
        upd      = 1'b0;
        unique case (state_q)
            ST_WAIT: begin
                if (enable && hit) begin
                    state_nx = (cmp_val == '0) ? ST_PULSE : ST_DELAY;
                end
            end
            ST_DELAY: begin
                if (!enable) begin
                    state_nx = ST_WAIT;
                end else if (tick && at_top) begin
                    state_nx = ST_WAIT;
                    upd      = 1'b1;
                end else if (tick && reach_cmp) begin
                    state_nx = ST_PULSE;
                end
            end
            ST_PULSE: begin
                if (!enable) begin
                    state_nx = ST_WAIT;
                end else if (tick && at_top) begin
                    state_nx = ST_WAIT;
                    upd      = 1'b1;
                end
            end
            default: state_nx = ST_WAIT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
        end else begin
            state_q <= state_nx;
        end
    end

    // registered outputs, aligned with the state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_out <= idle_lvl;
            done      <= 1'b0;
        end else begin
            pulse_out <= idle_lvl ^ (state_nx == ST_PULSE);
            done      <= upd;
        end
    end

endmodule

// File: rtl/tpg_checker.sv
module tpg_checker #(
    parameter int CNT_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                idle_lvl,
    input logic [CNT_W-1:0]    reload_val,
    input logic                pulse_out,
    input logic                done,
    input tpg_pkg::tpg_state_t state_q,
    input logic [CNT_W-1:0]    cnt
);
    import tpg_pkg::*;

    // R1 / R9: waiting always shows the idle level
    p_idle_when_waiting_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && $stable(idle_lvl)) |-> (pulse_out == idle_lvl));

    // R7 / R11: active state shows the inverse level
    p_active_inverse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PULSE && $stable(idle_lvl)) |-> (pulse_out != idle_lvl));

    // R9: update flag is a single cycle
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: update flag follows a count at the reload limit
    p_done_at_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(cnt) == $past(reload_val)));

    // R9: every run begins from zero
    p_start_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_WAIT && state_q != ST_WAIT) |-> (cnt == '0));

    // R10: within a run the count only holds or steps up by one
    p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) != ST_WAIT && state_q != ST_WAIT)
            |-> (cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'(1)));

endmodule

bind trig_pulse_gen tpg_checker #(.CNT_W(CNT_W)) u_tpg_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .idle_lvl   (idle_lvl),
    .reload_val (reload_val),
    .pulse_out  (pulse_out),
    .done       (done),
    .state_q    (state_q),
    .cnt        (cnt)
);

// File: tb/trig_pulse_gen_test.sv
module trig_pulse_gen_test;

    typedef struct packed {
        logic [1:0]  sel;
        logic        idle;
        logic        pre;
        logic        post;
        logic [15:0] cmp;
        logic [15:0] arr;
        logic [15:0] psc;
        logic        starts;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 1'b0, 1'b1, 16'd3, 16'd7, 16'd0, 1'b1},  // R2 rising
        '{2'd0, 1'b1, 1'b1, 1'b0, 16'd2, 16'd5, 16'd1, 1'b0},  // R2 falling ignored
        '{2'd1, 1'b1, 1'b1, 1'b0, 16'd2, 16'd5, 16'd1, 1'b1},  // R3 falling
        '{2'd2, 1'b0, 1'b1, 1'b0, 16'd0, 16'd4, 16'd2, 1'b1},  // R4 / R8 cmp zero
        '{2'd3, 1'b0, 1'b0, 1'b1, 16'd9, 16'd4, 16'd0, 1'b1},  // R4 / R8 cmp above limit
        '{2'd1, 1'b0, 1'b0, 1'b1, 16'd1, 16'd3, 16'd0, 1'b0},  // R3 rising ignored
        '{2'd2, 1'b1, 1'b0, 1'b1, 16'd4, 16'd4, 16'd3, 1'b1}   // R11 cmp at limit
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        trig = 1'b0;
    logic [1:0]  edge_sel = 2'd0;
    logic        idle_lvl = 1'b1;
    logic [15:0] cmp_val = 16'd0;
    logic [15:0] reload_val = 16'd0;
    logic [15:0] presc_val = 16'd0;
    logic        pulse_out;
    logic        done;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    trig_pulse_gen uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .trig       (trig),
        .edge_sel   (edge_sel),
        .idle_lvl   (idle_lvl),
        .cmp_val    (cmp_val),
        .reload_val (reload_val),
        .presc_val  (presc_val),
        .pulse_out  (pulse_out),
        .done       (done)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic setup(input vec_t v);
        @(negedge clk);
        enable     = 1'b0;
        edge_sel   = v.sel;
        idle_lvl   = v.idle;
        cmp_val    = v.cmp;
        reload_val = v.arr;
        presc_val  = v.psc;
        trig       = v.pre;
        repeat (4) @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
    endtask

    // samples win negedges after a trigger change made just after a negedge
    task automatic measure(input int win, input int kick_at,
                           output int first, output int act,
                           output int dn_idx, output int dn_cnt);
        first  = -1;
        act    = 0;
        dn_idx = -1;
        dn_cnt = 0;
        for (int k = 1; k <= win; k++) begin
            @(negedge clk);
            if (pulse_out != idle_lvl) begin
                act++;
                if (first < 0) first = k;
            end
            if (done) begin
                dn_cnt++;
                if (dn_idx < 0) dn_idx = k;
            end
            if (kick_at > 0 && k >= kick_at && k < kick_at + 6) trig = ~trig;
        end
    endtask

    task automatic run_vec(input vec_t v, input string req);
        int len, exp_first, exp_act, exp_done, win;
        int first, act, dn_idx, dn_cnt;
        len       = (int'(v.arr) + 1) * (int'(v.psc) + 1);
        exp_act   = (v.cmp > v.arr) ? 0 : (int'(v.arr) + 1 - int'(v.cmp)) * (int'(v.psc) + 1);
        exp_first = (exp_act == 0) ? -1 : 3 + int'(v.cmp) * (int'(v.psc) + 1);
        exp_done  = 3 + len;
        win       = len + 12;
        setup(v);
        trig = v.post;
        measure(win, 0, first, act, dn_idx, dn_cnt);
        if (v.starts) begin
            check(req, "first active sample (R6)", first, exp_first);
            check(req, "active length (R7)", act, exp_act);
            check(req, "update sample (R9)", dn_idx, exp_done);
            check(req, "update count (R9)", dn_cnt, 1);
        end else begin
            check(req, "no active output", act, 0);
            check(req, "no update", dn_cnt, 0);
        end
        check(req, "idle level after window (R11)", int'(pulse_out), int'(v.idle));
    endtask

    initial begin
        #(150000 * 5);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int first, act, dn_idx, dn_cnt;
        int f2, a2, d2, c2;
        vec_t rv;

        // R1: reset state with a high idle level
        repeat (3) @(negedge clk);
        check("R1", "pulse_out in reset", int'(pulse_out), 1);
        check("R1", "done in reset", int'(done), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", "pulse_out after reset", int'(pulse_out), 1);
        check("R1", "done after reset", int'(done), 0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i], $sformatf("vec%0d R2 R3 R4 R8", i));
        end

        // R5: enable low ignores edges
        rv = '{2'd2, 1'b0, 1'b0, 1'b1, 16'd1, 16'd3, 16'd0, 1'b0};
        setup(rv);
        enable = 1'b0;
        @(negedge clk);
        trig = 1'b1;
        measure(20, 4, first, act, dn_idx, dn_cnt);
        check("R5", "active samples with enable low", act, 0);
        check("R5", "update with enable low", dn_cnt, 0);
        check("R5", "output level", int'(pulse_out), 0);

        // R10: edges during a run are ignored
        rv = '{2'd2, 1'b0, 1'b0, 1'b1, 16'd2, 16'd9, 16'd1, 1'b1};
        setup(rv);
        trig = 1'b1;
        measure(40, 8, first, act, dn_idx, dn_cnt);
        check("R10", "first active with retrigger", first, 3 + 2 * 2);
        check("R10", "active length with retrigger", act, 8 * 2);
        check("R10", "update sample with retrigger", dn_idx, 3 + 20);
        check("R10", "update count with retrigger", dn_cnt, 1);

        // R9: back-to-back runs have identical timing
        rv = '{2'd0, 1'b1, 1'b0, 1'b1, 16'd1, 16'd2, 16'd1, 1'b1};
        setup(rv);
        trig = 1'b1;
        measure(12, 0, first, act, dn_idx, dn_cnt);
        trig = 1'b0;
        repeat (3) @(negedge clk);
        trig = 1'b1;
        measure(12, 0, f2, a2, d2, c2);
        check("R9", "second run first active", f2, first);
        check("R9", "second run active length", a2, act);
        check("R9", "second run update sample", d2, dn_idx);
        check("R11", "high idle gives low pulse", a2, 4);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule